// File: doc/BRIEF.md
# Gshare Next-PC Predictor

This unit sits beside the fetch stage of a five-stage pipeline and guesses the address to fetch next. Every cycle it looks up the fetch address in a 32-entry tagged target buffer and, at the same time, reads a 2-bit direction counter. That counter is picked by XORing a 5-bit global branch history with the low address bits, which is the gshare scheme. If the buffer hits and the instruction is a jump, or the counter's upper bit is set, the predicted address is the stored target. In every other case it is the sequential address.

The execute stage sends back one resolution per cycle. The resolution carries the instruction's address, its kind, the real outcome, the real target, and the next address that was predicted for it when it was fetched. The unit uses this to train the counters, shift the history, and fill the buffer. It also raises a one-cycle flag when the real next address differs from the predicted one. The pipeline uses that flag to squash the two younger instructions in fetch and decode.

Top module: `gsh_npc_pred`

## Requirements
- R1: After reset every buffer entry is invalid, every counter holds 01, and the history is zero. Until the first taken resolution, the prediction for any address is that address plus 4.
- R2: The prediction for the `fetch_pc` present at one rising edge appears on `pred_npc` after that edge and holds for the following cycle.
- R3: The buffer slot is address bits [6:2] and the tag is bits [31:7]. A lookup hits only if the slot is valid and the tags are equal. A taken resolution whose address aliases the slot overwrites the older owner, so that owner stops hitting.
- R4: `pred_npc` is the stored target when the lookup hits and either the entry was written by a jump or the selected counter's bit 1 is 1. Otherwise `pred_npc` is the fetch address plus 4.
- R5: The counter index is history XOR address bits [6:2]. A conditional resolution increments the indexed counter when taken and decrements it when not taken. The counter saturates at 00 and 11.
- R6: Each conditional resolution shifts its outcome into bit 0 of the 5-bit history. No other kind changes the history.
- R7: Every taken resolution writes its slot as valid, with its tag, its target, and a jump flag. Taken resolutions are conditional-taken, PC-relative jump and register jump. A not-taken conditional leaves the buffer unchanged.
- R8: `mispredict` is registered. It is high in the cycle after a valid resolution exactly when the real next address differs from `ex_pred_npc`. The real next address is `ex_target` for a jump or a taken conditional, and `ex_pc`+4 otherwise.
- R9: A lookup and an update that fall in the same cycle return the contents as they were before that update. This covers the buffer, the counter and the history.
- R10: `ex_kind` is coded as 0 = other, 1 = conditional, 2 = PC-relative jump, 3 = register jump. Kind 0 trains nothing but is still checked for a misprediction. When `ex_valid` is low, nothing changes and `mispredict` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_npc | output | 32 | Predicted next address, one cycle later |
| ex_valid | input | 1 | Resolution present this cycle |
| ex_kind | input | 2 | Instruction kind (R10 code) |
| ex_pc | input | 32 | Address of the resolved instruction |
| ex_taken | input | 1 | Actual direction of a conditional |
| ex_target | input | 32 | Actual taken target |
| ex_pred_npc | input | 32 | Next address predicted at fetch time |
| mispredict | output | 1 | Flush request, one cycle after resolution |

## Verification
The assertions assume that `ex_kind` is meaningful only while `ex_valid` is high. They also assume that jumps arrive with `ex_taken` in any state, because the unit treats every jump as taken. The stimulus uses word-aligned addresses drawn from two tag values across all 32 slots, so that hits, aliasing and counter saturation all occur often. The carried `ex_pred_npc` is picked from the sequential address, the real target, or the unit's own current guess, so that both the flush and no-flush cases appear for each kind.

// File: rtl/gsh_pkg.sv
package gsh_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_COND  = 2'd1,
    KIND_JAL   = 2'd2,
    KIND_JALR  = 2'd3
  } ctl_kind_e;
endpackage

// File: rtl/gsh_btb.sv
module gsh_btb #(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  output logic            lk_jump,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  input  logic            wr_jump
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int ENT_W = 1 + TAG_W + PC_W;

  logic [ENTRIES-1:0] valid;
  logic [ENT_W-1:0]   ent_mem [ENTRIES];
  logic [ENT_W-1:0]   ent_q;
  logic               vld_q;
  logic [TAG_W-1:0]   lk_tag_q;

  wire [IDX_W-1:0] lk_idx = lk_pc[IDX_W+1:2];
  wire [IDX_W-1:0] wr_idx = wr_pc[IDX_W+1:2];

  // data store: no reset, registered read, read-before-write
  always_ff @(posedge clk) begin
    ent_q <= ent_mem[lk_idx];
    if (wr_en) ent_mem[wr_idx] <= {wr_jump, wr_pc[PC_W-1:IDX_W+2], wr_target};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      vld_q    <= 1'b0;
      lk_tag_q <= '0;
    end else begin
      vld_q    <= valid[lk_idx];
      lk_tag_q <= lk_pc[PC_W-1:IDX_W+2];
      if (wr_en) valid[wr_idx] <= 1'b1;
    end
  end

  assign lk_jump   = ent_q[ENT_W-1];
  assign lk_target = ent_q[PC_W-1:0];
  assign lk_hit    = vld_q && (ent_q[PC_W +: TAG_W] == lk_tag_q);

  // R1
  btb_empty_after_reset_chk: assert property (@(posedge clk) rst |=> !lk_hit);
  // R7
  btb_valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(valid));
endmodule

// File: rtl/gsh_pht.sv
module gsh_pht #(
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(ENTRIES)-1:0] lk_idx,
  output logic [1:0]                 lk_ctr,
  input  logic                       up_en,
  input  logic [$clog2(ENTRIES)-1:0] up_idx,
  input  logic                       up_taken
);
  logic [ENTRIES-1:0][1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) cnt[i] <= 2'b01;
      lk_ctr <= 2'b01;
    end else begin
      lk_ctr <= cnt[lk_idx];
      if (up_en) begin
        if (up_taken && cnt[up_idx] != 2'b11)       cnt[up_idx] <= cnt[up_idx] + 2'd1;
        else if (!up_taken && cnt[up_idx] != 2'b00) cnt[up_idx] <= cnt[up_idx] - 2'd1;
      end
    end
  end

  // R5
  pht_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !up_en |=> $stable(cnt));
  // R5
  pht_taken_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (up_en && up_taken) |=> cnt[$past(up_idx)] != 2'b00);
  // R5
  pht_nt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (up_en && !up_taken) |=> cnt[$past(up_idx)] != 2'b11);
endmodule

// File: rtl/gsh_npc_pred.sv
module gsh_npc_pred #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  input  logic            ex_valid,
  input  logic [1:0]      ex_kind,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  input  logic [PC_W-1:0] ex_pred_npc,
  output logic            mispredict
);
  import gsh_pkg::*;
  localparam int ENTRIES = 1 << HIST_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  ctl_kind_e        kind;
  logic [HIST_W-1:0] ghr;
  logic [PC_W-1:0]  pc_q, actual_npc, btb_tgt;
  logic             is_cond, is_jump, act_taken, btb_hit, btb_jmp;
  logic [1:0]       ctr;

  assign kind       = ctl_kind_e'(ex_kind);
  assign is_cond    = ex_valid && (kind == KIND_COND);
  assign is_jump    = ex_valid && (kind == KIND_JAL || kind == KIND_JALR);
  assign act_taken  = is_jump || (is_cond && ex_taken);
  assign actual_npc = act_taken ? ex_target : ex_pc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      ghr        <= '0;
      pc_q       <= '0;
      mispredict <= 1'b0;
    end else begin
      pc_q       <= fetch_pc;
      mispredict <= ex_valid && (actual_npc != ex_pred_npc);
      if (is_cond) ghr <= {ghr[HIST_W-2:0], ex_taken};
    end
  end

  gsh_btb #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_btb (
    .clk(clk), .rst(rst),
    .lk_pc(fetch_pc), .lk_hit(btb_hit), .lk_target(btb_tgt), .lk_jump(btb_jmp),
    .wr_en(act_taken), .wr_pc(ex_pc), .wr_target(ex_target), .wr_jump(is_jump)
  );

  gsh_pht #(.ENTRIES(ENTRIES)) u_pht (
    .clk(clk), .rst(rst),
    .lk_idx(ghr ^ fetch_pc[HIST_W+1:2]), .lk_ctr(ctr),
    .up_en(is_cond), .up_idx(ghr ^ ex_pc[HIST_W+1:2]), .up_taken(ex_taken)
  );

  assign pred_npc = (btb_hit && (btb_jmp || ctr[1])) ? btb_tgt : pc_q + STEP;

  // R6
  ghr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    is_cond |=> ghr[0] == $past(ex_taken));
  // R10
  idle_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> !mispredict);
  // R8
  nt_correct_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cond && !ex_taken && ex_pred_npc == ex_pc + STEP) |=> !mispredict);
endmodule

// File: tb/gsh_npc_pred_test.sv
module gsh_npc_pred_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0, ex_pc = '0, ex_target = '0, ex_pred_npc = '0;
  logic        ex_valid = 1'b0, ex_taken = 1'b0;
  logic [1:0]  ex_kind = 2'd0;
  logic [31:0] pred_npc;
  logic        mispredict;

  int n_checks = 0, n_fail = 0;

  bit          m_vld [32];
  logic [24:0] m_tag [32];
  logic [31:0] m_tgt [32];
  bit          m_jmp [32];
  logic [1:0]  m_ctr [32];
  logic [4:0]  m_ghr;

  always #10 clk = ~clk;

  gsh_npc_pred uut (.clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
    .ex_valid(ex_valid), .ex_kind(ex_kind), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_target(ex_target), .ex_pred_npc(ex_pred_npc), .mispredict(mispredict));

  function automatic logic [31:0] m_pred(logic [31:0] pc);
    int i = int'(pc[6:2]);
    bit hit = m_vld[i] && m_tag[i] == pc[31:7];
    if (hit && (m_jmp[i] || m_ctr[int'(m_ghr ^ pc[6:2])][1])) return m_tgt[i];
    return pc + 32'd4;
  endfunction

  function automatic logic [31:0] m_actual(bit v, logic [1:0] k, logic [31:0] pc, bit t, logic [31:0] tg);
    if (v && (k >= 2'd2 || (k == 2'd1 && t))) return tg;
    return pc + 32'd4;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) begin
      m_vld[i] = 0; m_ctr[i] = 2'b01; m_tag[i] = '0; m_tgt[i] = '0; m_jmp[i] = 0;
    end
    m_ghr = '0;
  endtask

  task automatic m_update(bit v, logic [1:0] k, logic [31:0] pc, bit t, logic [31:0] tg);
    int i = int'(pc[6:2]);
    int c = int'(m_ghr ^ pc[6:2]);
    if (!v || k == 2'd0) return;
    if (k >= 2'd2 || t) begin
      m_vld[i] = 1; m_tag[i] = pc[31:7]; m_tgt[i] = tg; m_jmp[i] = (k >= 2'd2);
    end
    if (k == 2'd1) begin
      if (t && m_ctr[c] != 2'b11) m_ctr[c] = m_ctr[c] + 2'd1;
      else if (!t && m_ctr[c] != 2'b00) m_ctr[c] = m_ctr[c] - 2'd1;
      m_ghr = {m_ghr[3:0], t};
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, outputs checked at the next negedge
  task automatic cycle(string tp, string tm, logic [31:0] fpc, bit v, logic [1:0] k,
                       logic [31:0] pc, bit t, logic [31:0] tg, logic [31:0] pn);
    logic [31:0] ep;
    bit em;
    fetch_pc = fpc; ex_valid = v; ex_kind = k; ex_pc = pc; ex_taken = t;
    ex_target = tg; ex_pred_npc = pn;
    ep = m_pred(fpc);
    em = v && (m_actual(v, k, pc, t, tg) != pn);
    m_update(v, k, pc, t, tg);
    @(posedge clk); @(negedge clk);
    check(tp, pred_npc, ep);
    check(tm, {31'd0, mispredict}, {31'd0, em});
  endtask

  function automatic logic [31:0] rpc();
    logic [24:0] tg = ($urandom % 2 == 0) ? 25'h10 : 25'h33;
    return {tg, 5'($urandom), 2'b00};
  endfunction

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, a2, b;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 mispredict after reset", {31'd0, mispredict}, 32'd0);
    for (int j = 0; j < 4; j++) begin
      a = rpc();
      cycle("R1", "R10", a, 0, 2'd0, '0, 0, '0, '0);
    end
    a  = {25'h10, 5'd3, 2'b00};
    a2 = {25'h33, 5'd3, 2'b00};
    // R9: same-cycle write sees old contents; R8 mismatch flagged
    cycle("R9", "R8", a, 1, 2'd2, a, 0, 32'h0000_4000, a + 4);
    cycle("R7", "R10", a, 0, 2'd0, '0, 0, '0, '0);
    cycle("R3 alias miss", "R10", a2, 0, 2'd0, '0, 0, '0, '0);
    cycle("R9", "R8", a, 1, 2'd3, a2, 0, 32'h0000_5000, 32'h0000_5000);
    cycle("R3 overwritten", "R10", a, 0, 2'd0, '0, 0, '0, '0);
    cycle("R3 new owner", "R10", a2, 0, 2'd0, '0, 0, '0, '0);
    // R5 / R6: repeated conditional training at one address
    b = {25'h10, 5'd9, 2'b00};
    for (int j = 0; j < 8; j++)
      cycle("R5", "R6", b, 1, 2'd1, b, 1, 32'h0000_0800, b + 4);
    for (int j = 0; j < 8; j++)
      cycle("R5", "R6", b, 1, 2'd1, b, (j % 2 == 0), 32'h0000_0800, m_pred(b));
    // R7: not-taken conditional leaves buffer alone
    b = {25'h33, 5'd20, 2'b00};
    cycle("R7", "R8", b, 1, 2'd1, b, 0, 32'h0000_0900, b + 4);
    cycle("R7 nt no fill", "R10", b, 0, 2'd0, '0, 0, '0, '0);
    // R10: kind 0 flags but trains nothing; invalid slot ignored
    cycle("R10", "R10", b, 1, 2'd0, b, 1, 32'h0000_0a00, 32'h0000_0a00);
    cycle("R10 no fill", "R10", b, 1, 2'd2, b, 1, 32'h0000_0b00, b + 4 - 4);
    ex_valid = 0;
    cycle("R10 idle", "R10", b, 0, 2'd2, b, 1, 32'h0000_0c00, 32'h1);
    // random mix
    for (int j = 0; j < 3000; j++) begin
      logic [31:0] ep, tg, pn;
      logic [1:0]  k;
      bit v;
      ep = rpc(); tg = {16'h0, 14'($urandom), 2'b00};
      k = 2'($urandom); v = ($urandom % 4 != 0);
      case ($urandom % 4)
        0, 1: pn = ep + 4;
        2:    pn = tg;
        default: pn = m_pred(ep);
      endcase
      cycle("R4", "R8", rpc(), v, k, ep, 1'($urandom), tg, pn);
    end
    // R2: prediction follows fetch_pc one cycle later
    cycle("R2", "R10", a2, 0, 2'd0, '0, 0, '0, '0);
    cycle("R2", "R10", a2 + 4, 0, 2'd0, '0, 0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule